// File: doc/BRIEF.md
# Vector Floating-Point Compare-to-Mask Unit

This unit runs the vector floating-point compare instructions and builds one result bit per element into a destination mask. It decodes a 32-bit instruction word. The vector-vector form compares element i of the vs2 source with element i of the vs1 source. The vector-scalar form compares element i of vs2 with one scalar floating-point value. The vs2 element is always the left operand. The result is a packed bit mask, not numbers.

The caller supplies these inputs: the element width selector, the element count, a packed bus for each source vector, the scalar value, the old destination mask and the v0 mask. It then pulses `start`. The unit handles one element per clock in ascending index order. It merges each new bit into a copy of the old destination. When it finishes it pulses `done`, with the final mask on `result_mask`. An instruction the unit cannot decode, or an 8-bit element width, ends at once. In that case `illegal` is raised and the destination is left unchanged.

Top module: `vfcmp_mask_unit`

## Requirements
- R1: An instruction is accepted only when bits [6:0] are 1010111 and bits [14:12] are 001 (vector-vector) or 101 (vector-scalar). Any other value raises `illegal` together with `done`, one edge after `start`.
- R2: Bits [31:26] select the predicate. The encodings are 011000 equal, 011001 less-or-equal, 011011 less-than and 011100 not-equal in both forms, plus 011101 greater-than and 011111 greater-or-equal in the vector-scalar form only. Any other value, and greater-than or greater-or-equal in the vector-vector form, is illegal.
- R3: `sew_sel` encodes the element width as 0=8, 1=16, 2=32 and 3=64 bits. Width 8 is illegal, and `result_mask` then equals the old destination mask.
- R4: Each predicate is computed as (vs2 element) op (vs1 element or scalar), using IEEE-754 ordering.
- R5: If either operand is a NaN, equal, less-than, less-or-equal, greater-than and greater-or-equal are all 0, and not-equal is 1. Not-equal is always the inverse of equal.
- R6: +0 and -0 compare as equal.
- R7: When bit 25 is 1, every element is active. When it is 0, element i is active only if `v0_mask[i]` is 1. An inactive element keeps its bit from `old_mask`.
- R8: Bits at index count and above keep their `old_mask` value. A count above MAX_ELEMS is treated as MAX_ELEMS.
- R9: `done` is a one-cycle pulse, visible count+1 clock edges after the edge that samples `start`. A count of 0 finishes after one edge.
- R10: `vstart` holds the index of the element being processed. It reads k-1 after edge k of a run and returns to 0 when the run completes.
- R11: The sign, exponent and fraction fields are taken from the low SEW bits of each 64-bit element slot, or of the scalar. The upper bits of the slot are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken while idle) |
| instr | input | 32 | Instruction word |
| sew_sel | input | 2 | Element width code |
| elem_count | input | CW | Number of elements |
| vs2_elems | input | MAX_ELEMS*64 | Left-operand elements, one 64-bit slot each |
| vs1_elems | input | MAX_ELEMS*64 | Right-operand elements for the vector-vector form |
| scalar_op | input | 64 | Right operand for the vector-scalar form |
| old_mask | input | MAX_ELEMS | Previous destination mask |
| v0_mask | input | MAX_ELEMS | Element enable mask |
| result_mask | output | MAX_ELEMS | Destination mask result |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Illegal-instruction pulse |
| vstart | output | IW | Current element index |

## Verification
The assertions take for granted that `start` is raised only while the unit is idle. They also take for granted that the operand buses and the scalar stay stable until `done`, because those values are read live, one element per cycle. The bench drives every input one half-cycle away from the active edge. It waits for `done` before it changes anything, and it raises `start` for a single cycle per instruction. The sweeps cover every legal width and every predicate in both forms, special operand values (signed zeros, infinities, NaN, fractions), all 256 enable patterns, every count up to and beyond the limit, and garbage in the unused upper bits of each slot.

// File: rtl/vfcmp_mask_unit.sv
module vfcmp_mask_unit #(
  parameter int MAX_ELEMS = 8,
  localparam int CW = $clog2(MAX_ELEMS + 1),
  localparam int IW = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [31:0]             instr,
  input  logic [1:0]              sew_sel,
  input  logic [CW-1:0]           elem_count,
  input  logic [MAX_ELEMS*64-1:0] vs2_elems,
  input  logic [MAX_ELEMS*64-1:0] vs1_elems,
  input  logic [63:0]             scalar_op,
  input  logic [MAX_ELEMS-1:0]    old_mask,
  input  logic [MAX_ELEMS-1:0]    v0_mask,
  output logic [MAX_ELEMS-1:0]    result_mask,
  output logic                    done,
  output logic                    illegal,
  output logic [IW-1:0]           vstart
);

  localparam logic [5:0] OP_EQ = 6'b011000;
  localparam logic [5:0] OP_LE = 6'b011001;
  localparam logic [5:0] OP_LT = 6'b011011;
  localparam logic [5:0] OP_NE = 6'b011100;
  localparam logic [5:0] OP_GT = 6'b011101;
  localparam logic [5:0] OP_GE = 6'b011111;

  wire [5:0] in_f6     = instr[31:26];
  wire [2:0] in_f3     = instr[14:12];
  wire       in_scalar = (in_f3 == 3'b101);
  wire       form_ok   = (instr[6:0] == 7'b1010111) && (in_f3 == 3'b001 || in_f3 == 3'b101);
  wire       f6_ok     = (in_f6 == OP_EQ) || (in_f6 == OP_LE) || (in_f6 == OP_LT) || (in_f6 == OP_NE) ||
                         (in_scalar && (in_f6 == OP_GT || in_f6 == OP_GE));
  wire       bad_instr = !form_ok || !f6_ok || (sew_sel == 2'd0);
  wire [CW-1:0] cnt_clamped = (elem_count > CW'(MAX_ELEMS)) ? CW'(MAX_ELEMS) : elem_count;

  logic                 busy;
  logic [5:0]           op_l;
  logic                 scalar_l;
  logic                 all_on_l;
  logic [1:0]           sew_l;
  logic [CW-1:0]        cnt_l;
  logic [MAX_ELEMS-1:0] en_l;

  wire [63:0] elem_a = vs2_elems[{vstart, 6'b0} +: 64];
  wire [63:0] elem_b = scalar_l ? scalar_op : vs1_elems[{vstart, 6'b0} +: 64];
  wire        act    = all_on_l || en_l[vstart];

  function automatic logic [2:0] fp_order(input logic [1:0] w, input logic [63:0] a, input logic [63:0] b);
    logic sa, sb, na, nb, zz, eq, lt, gt;
    logic [62:0] ma, mb;
    case (w)
      2'd1: begin
        sa = a[15]; sb = b[15];
        ma = {48'b0, a[14:0]}; mb = {48'b0, b[14:0]};
        na = (a[14:10] == 5'h1f) && (a[9:0] != '0);
        nb = (b[14:10] == 5'h1f) && (b[9:0] != '0);
      end
      2'd2: begin
        sa = a[31]; sb = b[31];
        ma = {32'b0, a[30:0]}; mb = {32'b0, b[30:0]};
        na = (a[30:23] == 8'hff) && (a[22:0] != '0);
        nb = (b[30:23] == 8'hff) && (b[22:0] != '0);
      end
      default: begin
        sa = a[63]; sb = b[63];
        ma = a[62:0]; mb = b[62:0];
        na = (a[62:52] == 11'h7ff) && (a[51:0] != '0);
        nb = (b[62:52] == 11'h7ff) && (b[51:0] != '0);
      end
    endcase
    zz = (ma == '0) && (mb == '0);
    eq = zz || (sa == sb && ma == mb);
    if (sa != sb) begin
      lt = sa && !zz;
      gt = sb && !zz;
    end else if (!sa) begin
      lt = ma < mb;
      gt = ma > mb;
    end else begin
      lt = ma > mb;
      gt = ma < mb;
    end
    if (na || nb) return 3'b000;
    return {eq, lt, gt};
  endfunction

  wire [2:0] ord = fp_order(sew_l, elem_a, elem_b);
  logic bit_res;

  always_comb begin
    case (op_l)
      OP_EQ:   bit_res = ord[2];
      OP_LE:   bit_res = ord[2] | ord[1];
      OP_LT:   bit_res = ord[1];
      OP_NE:   bit_res = !ord[2];
      OP_GT:   bit_res = ord[0];
      default: bit_res = ord[2] | ord[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      illegal     <= 1'b0;
      vstart      <= '0;
      result_mask <= '0;
      op_l        <= '0;
      scalar_l    <= 1'b0;
      all_on_l    <= 1'b1;
      sew_l       <= 2'd1;
      cnt_l       <= '0;
      en_l        <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (busy) begin
        if (act) result_mask[vstart] <= bit_res;
        if ({1'b0, vstart} == cnt_l - 1'b1) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          vstart <= '0;
        end else begin
          vstart <= vstart + 1'b1;
        end
      end else if (start) begin
        result_mask <= old_mask;
        vstart      <= '0;
        op_l        <= in_f6;
        scalar_l    <= in_scalar;
        all_on_l    <= instr[25];
        sew_l       <= sew_sel;
        cnt_l       <= cnt_clamped;
        en_l        <= v0_mask;
        if (bad_instr || cnt_clamped == '0) begin
          done    <= 1'b1;
          illegal <= bad_instr;
        end else begin
          busy <= 1'b1;
        end
      end
    end
  end

  assert_illegal_keeps_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> result_mask == $past(old_mask));

  assert_illegal_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  assert_inactive_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !act) |=> $stable(result_mask));

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_vstart_zero_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vstart == '0);

  assert_vstart_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> vstart == $past(vstart) + 1'b1);

endmodule

// File: tb/test_vfcmp_mask_unit.sv
module test_vfcmp_mask_unit;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);
  localparam int IW = $clog2(N);

  logic            clk = 0;
  logic            rst_n = 0;
  logic            start = 0;
  logic [31:0]     instr = '0;
  logic [1:0]      sew_sel = 2'd1;
  logic [CW-1:0]   elem_count = '0;
  logic [N*64-1:0] vs2_elems = '0;
  logic [N*64-1:0] vs1_elems = '0;
  logic [63:0]     scalar_op = '0;
  logic [N-1:0]    old_mask = '0;
  logic [N-1:0]    v0_mask = '0;
  logic [N-1:0]    result_mask;
  logic            done;
  logic            illegal;
  logic [IW-1:0]   vstart;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  vfcmp_mask_unit #(.MAX_ELEMS(N)) i_vfcmp_mask_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .sew_sel(sew_sel),
    .elem_count(elem_count), .vs2_elems(vs2_elems), .vs1_elems(vs1_elems),
    .scalar_op(scalar_op), .old_mask(old_mask), .v0_mask(v0_mask),
    .result_mask(result_mask), .done(done), .illegal(illegal), .vstart(vstart)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // value index 0..9: +0 -0 +1 -1 +2 -2.5 +inf -inf NaN 0.5
  function automatic logic [63:0] enc(input int w, input int k);
    logic [15:0] h[10] = '{16'h0000, 16'h8000, 16'h3C00, 16'hBC00, 16'h4000,
                            16'hC100, 16'h7C00, 16'hFC00, 16'h7E00, 16'h3800};
    logic [31:0] s[10] = '{32'h0, 32'h80000000, 32'h3F800000, 32'hBF800000, 32'h40000000,
                            32'hC0200000, 32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'h3F000000};
    logic [63:0] d[10] = '{64'h0, 64'h8000000000000000, 64'h3FF0000000000000, 64'hBFF0000000000000,
                            64'h4000000000000000, 64'hC004000000000000, 64'h7FF0000000000000,
                            64'hFFF0000000000000, 64'h7FF8000000000000, 64'h3FE0000000000000};
    if (w == 1) return {48'hA5A5_5A5A_F00F, h[k]};
    if (w == 2) return {32'hDEAD_BEEF, s[k]};
    return d[k];
  endfunction

  function automatic real rval(input int k);
    real t[10] = '{0.0, 0.0, 1.0, -1.0, 2.0, -2.5, 1.0e300, -1.0e300, 0.0, 0.5};
    return t[k];
  endfunction

  function automatic bit pred(input logic [5:0] op, input int ka, input int kb);
    real a, b;
    if (ka == 8 || kb == 8) return op == 6'b011100;
    a = rval(ka);
    b = rval(kb);
    case (op)
      6'b011000: return a == b;
      6'b011001: return a <= b;
      6'b011011: return a < b;
      6'b011100: return a != b;
      6'b011101: return a > b;
      default:   return a >= b;
    endcase
  endfunction

  // runs one instruction; legal_exp=0 means an illegal outcome is expected
  task automatic run(input logic [5:0] op, input logic [2:0] f3, input logic [6:0] opc,
                     input bit vm, input int w, input int cnt, input int rot, input int sk,
                     input logic [N-1:0] en, input logic [N-1:0] old, input bit legal_exp,
                     input string req);
    logic [N-1:0] exp_mask;
    int eff, cyc;
    @(negedge clk);
    instr = {op, vm, 5'd2, 5'd1, f3, 5'd3, opc};
    sew_sel = 2'(w);
    elem_count = CW'(cnt);
    scalar_op = enc(w, sk);
    v0_mask = en;
    old_mask = old;
    for (int i = 0; i < N; i++) begin
      vs2_elems[i*64 +: 64] = enc(w, (i + rot) % 10);
      vs1_elems[i*64 +: 64] = enc(w, (3 * i + 7 * rot + 1) % 10);
    end
    eff = (cnt > N) ? N : cnt;
    exp_mask = old;
    if (legal_exp)
      for (int i = 0; i < eff; i++)
        if (vm || en[i])
          exp_mask[i] = pred(op, (i + rot) % 10, (f3 == 3'b101) ? sk : (3 * i + 7 * rot + 1) % 10);
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 40) begin
      check(vstart == IW'(cyc - 1), {req, " R10 vstart"}, vstart, cyc - 1);
      @(negedge clk);
      cyc++;
    end
    check(done == 1, {req, " R9 done seen"}, done, 1);
    check(cyc == (legal_exp ? eff + 1 : 1), {req, " R9 latency"}, cyc, legal_exp ? eff + 1 : 1);
    check(illegal == !legal_exp, {req, " R1 illegal flag"}, illegal, !legal_exp);
    check(result_mask == exp_mask, {req, " mask"}, result_mask, exp_mask);
    check(vstart == 0, {req, " R10 vstart cleared"}, vstart, 0);
    @(negedge clk);
    check(done == 0, {req, " R9 single pulse"}, done, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops[6] = '{6'b011000, 6'b011001, 6'b011011, 6'b011100, 6'b011101, 6'b011111};
    repeat (3) @(negedge clk);
    check(done == 0 && illegal == 0 && vstart == 0 && result_mask == 0, "reset state", {done, illegal}, 0);
    rst_n = 1;

    // R4 R5 R6 R11: all widths, all predicates, both forms, special values
    for (int w = 1; w <= 3; w++)
      for (int o = 0; o < 6; o++)
        for (int r = 0; r < 10; r++) begin
          run(ops[o], 3'b101, 7'b1010111, 1, w, N, r, r, 8'h00, 8'h3C, 1, "R4 R5 R6 R11 scalar");
          if (o < 4) run(ops[o], 3'b001, 7'b1010111, 1, w, N, r, 0, 8'h00, 8'hC3, 1, "R4 R5 R6 R11 vector");
        end

    // R7: every enable pattern with vm=0
    for (int p = 0; p < 256; p++)
      run(6'b011011, 3'b101, 7'b1010111, 0, 2, N, p % 10, 9, 8'(p), ~8'(p * 7), 1, "R7 enable mask");

    // R8 R9: every count, including above the limit
    for (int c = 0; c < 16; c++)
      run(6'b011100, 3'b001, 7'b1010111, 0, 3, c, c % 10, 0, 8'h5A, 8'hA5, 1, "R8 count");

    // R1 R2 R3: illegal encodings leave the destination unchanged
    run(6'b011000, 3'b101, 7'b1010111, 1, 0, N, 1, 2, 8'h00, 8'h96, 0, "R3 width 8");
    run(6'b011000, 3'b001, 7'b1010011, 1, 2, N, 1, 2, 8'h00, 8'h69, 0, "R1 bad opcode");
    run(6'b011000, 3'b000, 7'b1010111, 1, 2, N, 1, 2, 8'h00, 8'h0F, 0, "R1 funct3 000");
    run(6'b011000, 3'b011, 7'b1010111, 1, 2, N, 1, 2, 8'h00, 8'hF0, 0, "R1 funct3 011");
    run(6'b011101, 3'b001, 7'b1010111, 1, 2, N, 1, 2, 8'h00, 8'h55, 0, "R2 gt vector form");
    run(6'b011111, 3'b001, 7'b1010111, 1, 1, N, 1, 2, 8'h00, 8'hAA, 0, "R2 ge vector form");
    run(6'b000000, 3'b101, 7'b1010111, 1, 3, N, 1, 2, 8'h00, 8'h33, 0, "R2 funct6 000000");
    run(6'b011010, 3'b101, 7'b1010111, 1, 2, N, 1, 2, 8'h00, 8'hCC, 0, "R2 funct6 011010");
    run(6'b011110, 3'b101, 7'b1010111, 1, 2, N, 1, 2, 8'h00, 8'h11, 0, "R2 funct6 011110");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule